// File: doc/BRIEF.md
# Quad-Channel DAC Serial Frame Writer

This block drives a four-channel, 8-bit digital-to-analog converter over a three-wire serial link: a serial clock, a data line and an active-low frame sync. Software or an upstream engine hands it a list of channel updates as a byte stream on a valid/ready input. The first byte is the number of updates. Each update follows as two bytes: the 8-bit output value first, then the channel number.

For every update the block forms one 16-bit frame. The 8-bit value is split into two nibbles around a two-bit channel field and an immediate-update flag. The frame is shifted out most significant bit first while the frame sync is held low. Between frames the sync line returns high for at least one serial clock period. The input is not accepted while a frame is on the wire. Once the last frame of a list has finished, a one-cycle done pulse is raised and the block waits for the next count byte.

Top module: `qdac_frame_writer`

## Requirements
- R1: Frame bits 15:14 carry the low two bits of the channel byte. Upper bits of the channel byte have no effect on the frame.
- R2: Frame bit 12 is 1, requesting an immediate output update, and frame bit 13 is 0.
- R3: Frame bits 11:8 hold value bits 7:4, frame bits 7:4 hold value bits 3:0, and frame bits 3:0 are zero.
- R4: Every frame has exactly 16 bits, most significant first. The data line is valid at each rising edge of the serial clock. The serial clock rests low whenever the sync line is high.
- R5: The sync line falls while the serial clock is low, before the first rising edge. It stays low across all 16 bits and then returns high.
- R6: The input list is a count byte followed by that many value-then-channel byte pairs. Frames leave in list order, one per pair.
- R7: A count byte of zero produces no frame. It raises the done output on the cycle after the count is accepted.
- R8: Between two consecutive frames the sync line stays high for at least one serial clock period (2 × HALF_DIV system clocks).
- R9: The input ready signal is low whenever the sync line is low.
- R10: The done output is a single-cycle pulse, raised once per list after the last frame's sync line has returned high. No frame follows it until a new list is supplied.
- R11: After reset the sync line is high, the serial clock is low, done is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | List byte: count, value or channel |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block accepts in_data this cycle |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_sdo | output | 1 | Serial data to the converter, MSB first |
| dac_sync_n | output | 1 | Active-low frame sync |
| list_done | output | 1 | One-cycle pulse after the last frame of a list |

## Verification
Serial results have no fixed latency from the input bytes. A frame starts one cycle after its channel byte is accepted, and each serial clock level lasts HALF_DIV cycles. The bench therefore samples every output on the falling system clock edge and rebuilds frames from the observed serial clock rising edges, closing each word when sync returns high. The zero-count done pulse is due exactly one cycle after the count is accepted, so it is read on the first falling edge after that acceptance. For non-empty lists, done is awaited with a bounded wait, after which the frame count and quiet lines are checked a few cycles later.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int BYTE_W  = 8;
   localparam int CHAN_W  = 2;
   localparam int FRAME_W = 16;
   localparam int NIB_W   = BYTE_W / 2;

   typedef struct packed {
      logic [CHAN_W-1:0] chan;
      logic [BYTE_W-1:0] value;
   } qdac_entry_t;

   typedef enum logic [1:0] {
      SQ_COUNT = 2'd0,
      SQ_VALUE = 2'd1,
      SQ_CHAN  = 2'd2,
      SQ_WAIT  = 2'd3
   } seq_state_t;

   typedef enum logic [2:0] {
      SH_IDLE = 3'd0,
      SH_LOW  = 3'd1,
      SH_HIGH = 3'd2,
      SH_TAIL = 3'd3,
      SH_GAP  = 3'd4
   } shift_state_t;
endpackage

// File: rtl/qdac_list_seq.sv
module qdac_list_seq
   import qdac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              frame_busy,
   output logic              entry_load,
   output qdac_entry_t       entry,
   output logic              done
);
   seq_state_t        st;
   logic [BYTE_W-1:0] remain;
   logic [BYTE_W-1:0] val_q;
   logic              accept;

   // input is taken only while no frame is in flight
   assign in_ready = (st != SQ_WAIT);
   assign accept   = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_COUNT;
         remain     <= '0;
         val_q      <= '0;
         entry      <= '0;
         entry_load <= 1'b0;
         done       <= 1'b0;
      end else begin
         entry_load <= 1'b0;
         done       <= 1'b0;
         case (st)
            SQ_COUNT: if (accept) begin
               if (in_data == '0) begin
                  done <= 1'b1;
               end else begin
                  remain <= in_data;
                  st     <= SQ_VALUE;
               end
            end
            SQ_VALUE: if (accept) begin
               val_q <= in_data;
               st    <= SQ_CHAN;
            end
            SQ_CHAN: if (accept) begin
               entry.chan  <= in_data[CHAN_W-1:0];
               entry.value <= val_q;
               entry_load  <= 1'b1;
               remain      <= remain - BYTE_W'(1);
               st          <= SQ_WAIT;
            end
            SQ_WAIT: if (!frame_busy) begin
               if (remain == '0) begin
                  done <= 1'b1;
                  st   <= SQ_COUNT;
               end else begin
                  st <= SQ_VALUE;
               end
            end
            default: st <= SQ_COUNT;
         endcase
      end
   end
endmodule

// File: rtl/qdac_frame_fmt.sv
module qdac_frame_fmt
   import qdac_pkg::*;
#(
   parameter bit IMMEDIATE_UPDATE = 1'b1
) (
   input  qdac_entry_t        entry,
   output logic [FRAME_W-1:0] word
);
   logic upd_bit;

   generate
      if (IMMEDIATE_UPDATE) begin : g_upd_now
         assign upd_bit = 1'b1;
      end else begin : g_upd_deferred
         assign upd_bit = 1'b0;
      end
   endgenerate

   // channel, spare zero, update flag, high nibble | low nibble, zero pad
   assign word = {entry.chan, 1'b0, upd_bit,
                  entry.value[BYTE_W-1:NIB_W],
                  entry.value[NIB_W-1:0], {NIB_W{1'b0}}};
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
   import qdac_pkg::*;
#(
   parameter int HALF_DIV    = 2,
   parameter int GAP_PERIODS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] word,
   output logic               busy,
   output logic               sclk,
   output logic               sdo,
   output logic               sync_n
);
   localparam int DIV_W   = $clog2(HALF_DIV + 1);
   localparam int GAP_CYC = 2 * HALF_DIV * GAP_PERIODS;
   localparam int GAP_W   = $clog2(GAP_CYC + 1);
   localparam int BIT_W   = $clog2(FRAME_W);

   shift_state_t       st;
   logic [DIV_W-1:0]   hcnt;
   logic [GAP_W-1:0]   gcnt;
   logic [BIT_W-1:0]   bits;
   logic [FRAME_W-2:0] shreg;
   logic               half_end;

   assign half_end = (hcnt == DIV_W'(HALF_DIV - 1));
   assign busy     = (st != SH_IDLE) | load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SH_IDLE;
         hcnt   <= '0;
         gcnt   <= '0;
         bits   <= '0;
         shreg  <= '0;
         sclk   <= 1'b0;
         sdo    <= 1'b0;
         sync_n <= 1'b1;
      end else begin
         case (st)
            SH_IDLE: if (load) begin
               shreg  <= word[FRAME_W-2:0];
               sdo    <= word[FRAME_W-1];
               sync_n <= 1'b0;
               hcnt   <= '0;
               bits   <= '0;
               st     <= SH_LOW;
            end
            SH_LOW: begin
               if (half_end) begin
                  hcnt <= '0;
                  sclk <= 1'b1;
                  st   <= SH_HIGH;
               end else begin
                  hcnt <= hcnt + DIV_W'(1);
               end
            end
            SH_HIGH: begin
               if (half_end) begin
                  hcnt <= '0;
                  sclk <= 1'b0;
                  if (bits == BIT_W'(FRAME_W - 1)) begin
                     st <= SH_TAIL;
                  end else begin
                     sdo   <= shreg[FRAME_W-2];
                     shreg <= {shreg[FRAME_W-3:0], 1'b0};
                     bits  <= bits + BIT_W'(1);
                     st    <= SH_LOW;
                  end
               end else begin
                  hcnt <= hcnt + DIV_W'(1);
               end
            end
            SH_TAIL: begin
               if (half_end) begin
                  hcnt   <= '0;
                  sync_n <= 1'b1;
                  sdo    <= 1'b0;
                  gcnt   <= '0;
                  st     <= SH_GAP;
               end else begin
                  hcnt <= hcnt + DIV_W'(1);
               end
            end
            SH_GAP: begin
               if (gcnt == GAP_W'(GAP_CYC - 1)) st <= SH_IDLE;
               else                            gcnt <= gcnt + GAP_W'(1);
            end
            default: st <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/qdac_frame_writer.sv
module qdac_frame_writer
   import qdac_pkg::*;
#(
   parameter int HALF_DIV         = 2,
   parameter int GAP_PERIODS      = 1,
   parameter bit IMMEDIATE_UPDATE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   output logic       dac_sclk,
   output logic       dac_sdo,
   output logic       dac_sync_n,
   output logic       list_done
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (GAP_PERIODS < 1) begin : g_bad_gap
         $error("GAP_PERIODS must be at least 1");
      end
   endgenerate

   qdac_entry_t        entry;
   logic               entry_load;
   logic               frame_busy;
   logic [FRAME_W-1:0] frame_word;

   qdac_list_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .frame_busy (frame_busy),
      .entry_load (entry_load),
      .entry      (entry),
      .done       (list_done)
   );

   qdac_frame_fmt #(.IMMEDIATE_UPDATE(IMMEDIATE_UPDATE)) u_fmt (
      .entry (entry),
      .word  (frame_word)
   );

   qdac_shifter #(.HALF_DIV(HALF_DIV), .GAP_PERIODS(GAP_PERIODS)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (entry_load),
      .word   (frame_word),
      .busy   (frame_busy),
      .sclk   (dac_sclk),
      .sdo    (dac_sdo),
      .sync_n (dac_sync_n)
   );
endmodule

// File: rtl/qdac_writer_checker.sv
module qdac_writer_checker #(
   parameter int HALF_DIV = 2
) (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic dac_sclk,
   input logic dac_sdo,
   input logic dac_sync_n,
   input logic list_done
);
   localparam int GAP_MIN = 2 * HALF_DIV;
   localparam int GC_W    = $clog2(GAP_MIN + 1);

   logic [4:0]      bit_cnt;
   logic            sclk_q;
   logic [GC_W-1:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sclk_q  <= 1'b0;
         gap_cnt <= GC_W'(GAP_MIN);
      end else begin
         sclk_q <= dac_sclk;
         if (dac_sync_n)                 bit_cnt <= '0;
         else if (dac_sclk && !sclk_q)   bit_cnt <= bit_cnt + 5'd1;
         if (!dac_sync_n)                gap_cnt <= '0;
         else if (gap_cnt < GC_W'(GAP_MIN)) gap_cnt <= gap_cnt + GC_W'(1);
      end
   end

   assert_sixteen_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_sync_n) |-> (bit_cnt == 5'd16));

   assert_sclk_rests_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sync_n |-> !dac_sclk);

   assert_sdo_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));

   assert_sync_falls_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sync_n) |-> !dac_sclk);

   assert_gap_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sync_n) |-> (gap_cnt >= GC_W'(GAP_MIN)));

   assert_no_ready_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_sync_n |-> !in_ready);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |=> !list_done);

   assert_done_sync_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |-> dac_sync_n);
endmodule

bind qdac_frame_writer qdac_writer_checker #(.HALF_DIV(HALF_DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .dac_sclk   (dac_sclk),
   .dac_sdo    (dac_sdo),
   .dac_sync_n (dac_sync_n),
   .list_done  (list_done)
);

// File: tb/sim_qdac_frame_writer.sv
module sim_qdac_frame_writer;
   localparam int HALF = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready, dac_sclk, dac_sdo, dac_sync_n, list_done;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   qdac_frame_writer #(.HALF_DIV(HALF), .GAP_PERIODS(1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
      .dac_sync_n(dac_sync_n), .list_done(list_done)
   );

   // capture state
   logic [15:0] cap [0:31];
   int          cap_n = 0;
   int          done_cnt = 0;
   logic [15:0] shw = '0;
   int          nb = 0;
   int          gapc = 1000;
   logic        prev_s = 1'b1, prev_k = 1'b0;

   logic [7:0] lv [0:15];
   logic [7:0] lc [0:15];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (list_done) done_cnt++;
         if (!dac_sync_n && dac_sclk && !prev_k) begin
            shw = {shw[14:0], dac_sdo};
            nb++;
         end
         if (dac_sync_n && !prev_s) begin
            if (cap_n < 32) cap[cap_n] = shw;
            cap_n++;
            check(nb == 16, "R4 bits per frame", nb, 16);
            gapc = 0;
         end
         if (!dac_sync_n && prev_s) begin
            check(gapc >= 2*HALF, "R8 sync high gap", gapc, 2*HALF);
            check(!dac_sclk, "R5 sclk low at sync fall", dac_sclk, 0);
            nb = 0;
            shw = '0;
         end
         if (dac_sync_n) gapc++;
         if (dac_sync_n && dac_sclk) check(1'b0, "R4 sclk toggling outside frame", 1, 0);
         if (!dac_sync_n && in_ready) check(1'b0, "R9 ready during frame", 1, 0);
         prev_s = dac_sync_n;
         prev_k = dac_sclk;
      end
   end

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      in_data  = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_list(input int n, input string tag);
      logic [15:0] e;
      int t;
      cap_n = 0;
      done_cnt = 0;
      send_byte(8'(n));
      for (int i = 0; i < n; i++) begin
         send_byte(lv[i]);
         send_byte(lc[i]);
      end
      t = 0;
      while (done_cnt == 0 && t < 20000) begin
         @(negedge clk);
         t++;
      end
      repeat (6) @(negedge clk);
      check(cap_n == n, {"R6 frame count ", tag}, cap_n, n);
      check(done_cnt == 1, {"R10 one done ", tag}, done_cnt, 1);
      check(dac_sync_n && !dac_sclk, {"R10 quiet after done ", tag}, dac_sync_n, 1);
      for (int i = 0; i < n && i < cap_n; i++) begin
         e = {lc[i][1:0], 1'b0, 1'b1, lv[i][7:4], lv[i][3:0], 4'h0};
         check(cap[i][15:14] == lc[i][1:0], {"R1 channel field ", tag}, cap[i][15:14], lc[i][1:0]);
         check(cap[i][13:12] == 2'b01, {"R2 flag bits ", tag}, cap[i][13:12], 1);
         check(cap[i][11:0] == {lv[i], 4'h0}, {"R3 value nibbles ", tag}, cap[i][11:0], {lv[i], 4'h0});
         check(cap[i] == e, {"R6 frame order ", tag}, cap[i], e);
      end
   endtask

   task automatic t_reset;
      check(dac_sync_n == 1'b1, "R11 sync high", dac_sync_n, 1);
      check(dac_sclk == 1'b0, "R11 sclk low", dac_sclk, 0);
      check(list_done == 1'b0, "R11 done low", list_done, 0);
      check(in_ready == 1'b1, "R11 ready high", in_ready, 1);
   endtask

   task automatic t_single;
      lv[0] = 8'hA5; lc[0] = 8'd3;
      run_list(1, "single");
   endtask

   task automatic t_all_channels;
      lv[0] = 8'h12; lc[0] = 8'd0;
      lv[1] = 8'h34; lc[1] = 8'd1;
      lv[2] = 8'h56; lc[2] = 8'd2;
      lv[3] = 8'h78; lc[3] = 8'd3;
      run_list(4, "four");
   endtask

   task automatic t_extremes;
      lv[0] = 8'h00; lc[0] = 8'd1;
      lv[1] = 8'hFF; lc[1] = 8'd2;
      lv[2] = 8'h0F; lc[2] = 8'd0;
      run_list(3, "extremes");
   endtask

   task automatic t_upper_chan_bits;
      // R1: channel byte bits 7:2 must not reach the frame
      lv[0] = 8'h3C; lc[0] = 8'hFE;
      lv[1] = 8'hC3; lc[1] = 8'h7D;
      run_list(2, "upper bits");
   endtask

   task automatic t_zero_count;
      cap_n = 0;
      done_cnt = 0;
      send_byte(8'd0);
      check(list_done == 1'b1, "R7 done next cycle", list_done, 1);
      repeat (20) @(negedge clk);
      check(cap_n == 0, "R7 no frames", cap_n, 0);
      check(done_cnt == 1, "R7 single done", done_cnt, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_all_channels();
      t_zero_count();
      t_extremes();
      t_upper_chan_bits();
      t_single();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule